// File: doc/BRIEF.md
# Pixel Controller Register and Status Block

This block is the byte-wide register file of an LED pixel-strip controller. A command front end issues single-byte reads and writes over a simple 8-bit address and data bus. The block holds the settings that the serializer and the FIFO logic consume: enable and mode bits, the colour-order byte, six bit-timing bytes, the run bit and two general-purpose outputs.

The block also watches the pixel FIFO. It takes the fill level, the full and empty flags, and single-cycle overflow and underflow events. From the fill level and two programmable 11-bit thresholds it produces registered almost-full and almost-empty pins. The same flags appear in a live status byte that the master can poll for flow control.

The six timing bytes may only change while the controller is idle. A write to them while the controller is enabled and the FIFO still holds data is discarded and raises a sticky write-error flag. That flag is cleared by writing a 1 to its status bit, as are the sticky overflow and underflow flags.

Top module: `pxl_regblk`

## Requirements
- R1: After reset: cfg_enable, cfg_mode, run_o, gpo_oe, gpo_out and all sticky flags are 0. The timing bytes hold their default parameters (0x07 reads 0x04). The almost-full threshold is 1020 (0x03 reads 0x03, 0x04 reads 0xFC).
- R2: Writes land at these addresses: configuration 0x01 (bit1 mode, bit0 enable), colour-order byte 0x02 (8 bits), run 0x0D (bit0), GPO value 0xF0 and GPO direction 0xF1 (bits[1:0]), scratch bytes 0xF2..0xF5. A read with rd_en presents the addressed byte on rd_data one clock later.
- R3: Reserved bits read as 0. Any address outside 0x00..0x0D and 0xF0..0xF5 reads 0x00, and writes to it have no effect.
- R4: The almost-full threshold is 11 bits: 0x03 bits[2:0] hold the upper 3 bits and 0x04 holds the lower 8 bits. The almost-empty threshold uses 0x05 and 0x06 in the same way.
- R5: afull_o is 1 exactly when the fill level sampled on the previous clock was greater than or equal to the almost-full threshold.
- R6: aempty_o is 1 exactly when the fill level sampled on the previous clock was less than or equal to the almost-empty threshold.
- R7: The status byte at 0x00 has this layout: bit0 = FIFO empty, bit1 = FIFO full, bit2 = almost empty, bit3 = almost full, bit4 = underflow, bit5 = overflow, bit6 = write error, bit7 = 0. The empty and full bits follow the inputs live.
- R8: A write to a timing byte (0x07 zero-high, 0x08 zero-low, 0x09 one-high, 0x0A one-low, 0x0B reset-cycle, 0x0C reset-code) takes effect when enable is 0 or the FIFO is empty.
- R9: A timing write made while enable is 1 and the FIFO is not empty is dropped: the byte and its output keep their value, and the write-error flag (status bit6, werr_o) is set.
- R10: The overflow and underflow flags set on their event pulses and stay set. Writing a 1 to a flag's status bit clears it, and writing 0 leaves it. An event in the same cycle as a clear wins.
- R11: gpo_out carries the GPO value bits. gpo_oe carries the direction bits: 1 means the pin is driven, 0 means it is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | write strobe |
| rd_en | input | 1 | read strobe |
| addr | input | 8 | register address |
| wr_data | input | 8 | write data |
| rd_data | output | 8 | read data, valid the cycle after rd_en |
| fifo_lvl | input | 11 | FIFO fill level |
| fifo_full | input | 1 | FIFO full |
| fifo_empty | input | 1 | FIFO empty |
| fifo_ovf | input | 1 | overflow event pulse |
| fifo_unf | input | 1 | underflow event pulse |
| afull_o | output | 1 | almost-full pin |
| aempty_o | output | 1 | almost-empty pin |
| werr_o | output | 1 | sticky write-error flag |
| cfg_enable | output | 1 | controller enable |
| cfg_mode | output | 1 | operating mode |
| wrgb_fmt | output | 8 | colour-order byte |
| t_zero_hi | output | 8 | zero-bit high time |
| t_zero_lo | output | 8 | zero-bit low time |
| t_one_hi | output | 8 | one-bit high time |
| t_one_lo | output | 8 | one-bit low time |
| t_rst_cycle | output | 8 | reset-cycle length |
| t_rst_code | output | 8 | reset-code length |
| run_o | output | 1 | run/stop |
| gpo_out | output | 2 | GPO pin values |
| gpo_oe | output | 2 | GPO drive enables |

## Verification
The bench uses the default parameters: an 11-bit level, two GPO pins, four scratch bytes, and the default timing and threshold values. With an 11-bit level, thresholds above 255 can be programmed, so the upper-byte path and the one-below, equal and one-above cases around a threshold of 256 are all exercised. The FIFO inputs are driven directly from the bench. This allows the enable and empty combinations of the timing guard to be set up, and an event pulse to coincide with a status clear.

// File: rtl/pxl_regblk_pkg.sv
package pxl_regblk_pkg;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_CFG  = 8'h01;
  localparam logic [7:0] A_FMT  = 8'h02;
  localparam logic [7:0] A_AFH  = 8'h03;
  localparam logic [7:0] A_AFL  = 8'h04;
  localparam logic [7:0] A_AEH  = 8'h05;
  localparam logic [7:0] A_AEL  = 8'h06;
  localparam logic [7:0] A_TIM0 = 8'h07;
  localparam logic [7:0] A_RUN  = 8'h0D;
  localparam logic [7:0] A_GPV  = 8'hF0;
  localparam logic [7:0] A_GPD  = 8'hF1;
  localparam logic [7:0] A_SCR0 = 8'hF2;
  localparam int TIM_N = 6;

  function automatic logic in_win(input logic [7:0] a, input logic [7:0] base, input int n);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
  endfunction
endpackage

// File: rtl/pxl_lvl_cmp.sv
module pxl_lvl_cmp #(
  parameter int W = 11,
  parameter bit AT_LEAST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] thr,
  output logic         hit
);
  logic raw;

  generate
    if (AT_LEAST) begin : g_ge
      assign raw = (lvl >= thr);
      assert_ge_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hit == ($past(lvl) >= $past(thr))));
    end else begin : g_le
      assign raw = (lvl <= thr);
      assert_le_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hit == ($past(lvl) <= $past(thr))));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= raw;
  end
endmodule

// File: rtl/pxl_sticky.sv
module pxl_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)         q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end
      assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (q[i] && !clr[i]) |=> q[i]);
      assert_set_R10: assert property (@(posedge clk) disable iff (rst)
        set[i] |=> q[i]);
    end
  endgenerate
endmodule

// File: rtl/pxl_regblk.sv
module pxl_regblk
  import pxl_regblk_pkg::*;
#(
  parameter int LVL_W = 11,
  parameter int GPO_N = 2,
  parameter int SCR_N = 4,
  parameter logic [LVL_W-1:0] DEF_AF = 11'd1020,
  parameter logic [LVL_W-1:0] DEF_AE = 11'd4,
  parameter logic [TIM_N*8-1:0] TIM_DEF = {8'd60, 8'd60, 8'd6, 8'd8, 8'd9, 8'd4}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             fifo_ovf,
  input  logic             fifo_unf,
  output logic             afull_o,
  output logic             aempty_o,
  output logic             werr_o,
  output logic             cfg_enable,
  output logic             cfg_mode,
  output logic [7:0]       wrgb_fmt,
  output logic [7:0]       t_zero_hi,
  output logic [7:0]       t_zero_lo,
  output logic [7:0]       t_one_hi,
  output logic [7:0]       t_one_lo,
  output logic [7:0]       t_rst_cycle,
  output logic [7:0]       t_rst_code,
  output logic             run_o,
  output logic [GPO_N-1:0] gpo_out,
  output logic [GPO_N-1:0] gpo_oe
);
  localparam int HI_W   = LVL_W - 8;
  localparam int TIM_IW = $clog2(TIM_N);
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  logic [LVL_W-1:0]   af_thr, ae_thr;
  logic [GPO_N-1:0]   gpv_q, gpd_q;
  logic [TIM_N*8-1:0] tim_flat;
  logic [SCR_N*8-1:0] scr_flat;
  logic [2:0]         stk_q, stk_set, stk_clr;
  logic               tim_hit, tim_ok, mapped;
  logic [7:0]         stat, rd_mux;

  assign tim_hit = in_win(addr, A_TIM0, TIM_N);
  assign tim_ok  = !cfg_enable || fifo_empty;
  assign mapped  = (addr <= A_RUN) || in_win(addr, A_GPV, 2 + SCR_N);

  // control and threshold registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_enable <= 1'b0;
      cfg_mode   <= 1'b0;
      wrgb_fmt   <= 8'h00;
      af_thr     <= DEF_AF;
      ae_thr     <= DEF_AE;
      run_o      <= 1'b0;
      gpv_q      <= '0;
      gpd_q      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CFG: begin cfg_enable <= wr_data[0]; cfg_mode <= wr_data[1]; end
        A_FMT: wrgb_fmt <= wr_data;
        A_AFH: af_thr[LVL_W-1:8] <= wr_data[HI_W-1:0];
        A_AFL: af_thr[7:0] <= wr_data;
        A_AEH: ae_thr[LVL_W-1:8] <= wr_data[HI_W-1:0];
        A_AEL: ae_thr[7:0] <= wr_data;
        A_RUN: run_o <= wr_data[0];
        A_GPV: gpv_q <= wr_data[GPO_N-1:0];
        A_GPD: gpd_q <= wr_data[GPO_N-1:0];
        default: ;
      endcase
    end
  end

  // guarded timing bytes
  generate
    for (genvar i = 0; i < TIM_N; i++) begin : g_tim
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= TIM_DEF[i*8 +: 8];
        else if (wr_en && tim_ok && addr == (A_TIM0 + 8'(i))) q <= wr_data;
      end
      assign tim_flat[i*8 +: 8] = q;
    end
    for (genvar j = 0; j < SCR_N; j++) begin : g_scr
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= 8'h00;
        else if (wr_en && addr == (A_SCR0 + 8'(j))) q <= wr_data;
      end
      assign scr_flat[j*8 +: 8] = q;
    end
  endgenerate

  assign t_zero_hi   = tim_flat[7:0];
  assign t_zero_lo   = tim_flat[15:8];
  assign t_one_hi    = tim_flat[23:16];
  assign t_one_lo    = tim_flat[31:24];
  assign t_rst_cycle = tim_flat[39:32];
  assign t_rst_code  = tim_flat[47:40];
  assign gpo_out     = gpv_q;
  assign gpo_oe      = gpd_q;

  // sticky flags: index 0 under, 1 over, 2 write error
  assign stk_set = {wr_en && tim_hit && !tim_ok, fifo_ovf, fifo_unf};
  assign stk_clr = (wr_en && addr == A_STAT) ? wr_data[6:4] : 3'b000;

  pxl_sticky #(.N(3)) u_stk (
    .clk(clk), .rst(rst), .set(stk_set), .clr(stk_clr), .q(stk_q)
  );
  assign werr_o = stk_q[2];

  pxl_lvl_cmp #(.W(LVL_W), .AT_LEAST(1'b1)) u_af (
    .clk(clk), .rst(rst), .lvl(fifo_lvl), .thr(af_thr), .hit(afull_o)
  );
  pxl_lvl_cmp #(.W(LVL_W), .AT_LEAST(1'b0)) u_ae (
    .clk(clk), .rst(rst), .lvl(fifo_lvl), .thr(ae_thr), .hit(aempty_o)
  );

  assign stat = {1'b0, stk_q, afull_o, aempty_o, fifo_full, fifo_empty};

  always_comb begin
    rd_mux = 8'h00;
    if (addr == A_STAT)     rd_mux = stat;
    else if (addr == A_CFG) rd_mux = {6'b0, cfg_mode, cfg_enable};
    else if (addr == A_FMT) rd_mux = wrgb_fmt;
    else if (addr == A_AFH) rd_mux = 8'(af_thr[LVL_W-1:8]);
    else if (addr == A_AFL) rd_mux = af_thr[7:0];
    else if (addr == A_AEH) rd_mux = 8'(ae_thr[LVL_W-1:8]);
    else if (addr == A_AEL) rd_mux = ae_thr[7:0];
    else if (tim_hit)       rd_mux = tim_flat[TIM_IW'(addr - A_TIM0)*8 +: 8];
    else if (addr == A_RUN) rd_mux = {7'b0, run_o};
    else if (addr == A_GPV) rd_mux = 8'(gpv_q);
    else if (addr == A_GPD) rd_mux = 8'(gpd_q);
    else if (in_win(addr, A_SCR0, SCR_N))
      rd_mux = scr_flat[SCR_IW'(addr - A_SCR0)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_tim_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tim_hit && cfg_enable && !fifo_empty) |=> ($stable(tim_flat) && werr_o));
  assert_unmapped_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rd_data == 8'h00));
  assert_stat_rsvd_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT) |=> (rd_data[7] == 1'b0));
  assert_cfg_rsvd_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CFG) |=> (rd_data[7:2] == 6'b0));
endmodule

// File: tb/pxl_regblk_tb.sv
module pxl_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0, wr_data = 0;
  logic [7:0]  rd_data;
  logic [10:0] fifo_lvl = 0;
  logic        fifo_full = 0, fifo_empty = 1, fifo_ovf = 0, fifo_unf = 0;
  logic        afull_o, aempty_o, werr_o, cfg_enable, cfg_mode, run_o;
  logic [7:0]  wrgb_fmt, t_zero_hi, t_zero_lo, t_one_hi, t_one_lo, t_rst_cycle, t_rst_code;
  logic [1:0]  gpo_out, gpo_oe;
  int total = 0, bad = 0;
  logic done = 0;

  always #5 clk = ~clk;

  pxl_regblk dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .fifo_lvl(fifo_lvl),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf),
    .fifo_unf(fifo_unf), .afull_o(afull_o), .aempty_o(aempty_o),
    .werr_o(werr_o), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .wrgb_fmt(wrgb_fmt), .t_zero_hi(t_zero_hi), .t_zero_lo(t_zero_lo),
    .t_one_hi(t_one_hi), .t_one_lo(t_one_lo), .t_rst_cycle(t_rst_cycle),
    .t_rst_code(t_rst_code), .run_o(run_o), .gpo_out(gpo_out), .gpo_oe(gpo_oe)
  );

  // {addr, write data, expected read-back}
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    24'h02A5A5, 24'h03FF07, 24'h043C3C, 24'h05FA02, 24'h061111,
    24'h071212, 24'h083434, 24'h095656, 24'h0A7878, 24'h0B9A9A,
    24'h0CBCBC, 24'h0DFF01, 24'hF0FF03, 24'hF1FE02, 24'hF21111,
    24'hF32222, 24'hF43333, 24'hF54444, 24'h0E5500, 24'hF65A00,
    24'h01FF03, 24'h010000
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // reset state
    chk("R1 cfg_enable", cfg_enable, 0);
    chk("R1 run_o", run_o, 0);
    chk("R1 gpo_oe", gpo_oe, 0);
    chk("R1 werr_o", werr_o, 0);
    chk("R1 t_zero_hi", t_zero_hi, 8'h04);
    chk("R5 afull_o at reset", afull_o, 0);
    chk("R6 aempty_o at reset", aempty_o, 1);
    rd(8'h07, r); chk("R1 timing 0x07", r, 8'h04);
    rd(8'h03, r); chk("R1 afull hi", r, 8'h03);
    rd(8'h04, r); chk("R1 afull lo", r, 8'hFC);
    rd(8'h00, r); chk("R7 status after reset", r, 8'h05);

    // table walk: R2 map, R3 masking and unmapped, R4 threshold bytes, R8 idle timing writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], r);
      chk($sformatf("R2/R3/R4 vec%0d addr %0h", i, VEC[i][23:16]), r, VEC[i][7:0]);
    end
    chk("R2 wrgb_fmt port", wrgb_fmt, 8'hA5);
    chk("R8 t_rst_code port", t_rst_code, 8'hBC);
    chk("R11 gpo_out", gpo_out, 2'b11);
    chk("R11 gpo_oe", gpo_oe, 2'b10);
    wr(8'hF1, 8'h01);
    chk("R11 gpo_oe swap", gpo_oe, 2'b01);

    // thresholds: almost-full 256, almost-empty 16
    wr(8'h03, 8'h01); wr(8'h04, 8'h00);
    wr(8'h05, 8'h00); wr(8'h06, 8'h10);
    fifo_empty = 0;
    fifo_lvl = 255; @(negedge clk); chk("R5 lvl 255 below", afull_o, 0);
    fifo_lvl = 256; @(negedge clk); chk("R5 lvl 256 equal", afull_o, 1);
    fifo_lvl = 257; @(negedge clk); chk("R5 lvl 257 above", afull_o, 1);
    fifo_lvl = 16;  @(negedge clk); chk("R6 lvl 16 equal", aempty_o, 1);
    fifo_lvl = 17;  @(negedge clk); chk("R6 lvl 17 above", aempty_o, 0);
    fifo_lvl = 15;  @(negedge clk); chk("R6 lvl 15 below", aempty_o, 1);
    fifo_lvl = 256;
    rd(8'h00, r); chk("R7 status afull", r, 8'h08);
    fifo_full = 1;
    rd(8'h00, r); chk("R7 status afull+full", r, 8'h0A);
    fifo_full = 0; fifo_lvl = 100;
    rd(8'h00, r); chk("R7 status mid level", r, 8'h00);

    // timing guard
    wr(8'h01, 8'h01);
    wr(8'h07, 8'hEE);
    rd(8'h07, r); chk("R9 dropped write", r, 8'h12);
    chk("R9 t_zero_hi kept", t_zero_hi, 8'h12);
    chk("R9 werr_o", werr_o, 1);
    rd(8'h00, r); chk("R9 status werr", r, 8'h40);
    fifo_empty = 1;
    wr(8'h07, 8'hEE);
    rd(8'h07, r); chk("R8 enabled but empty", r, 8'hEE);
    rd(8'h00, r); chk("R7 status werr+empty", r, 8'h41);
    fifo_empty = 0;
    wr(8'h00, 8'h40);
    rd(8'h00, r); chk("R10 werr cleared", r, 8'h00);
    wr(8'h01, 8'h00);
    wr(8'h08, 8'h77);
    rd(8'h08, r); chk("R8 disabled not empty", r, 8'h77);
    chk("R8 werr stays clear", werr_o, 0);

    // sticky events
    @(negedge clk); fifo_ovf = 1;
    @(negedge clk); fifo_ovf = 0;
    rd(8'h00, r); chk("R10 over set", r, 8'h20);
    wr(8'h00, 8'h10);
    rd(8'h00, r); chk("R10 over kept on other clear", r, 8'h20);
    wr(8'h00, 8'h20);
    rd(8'h00, r); chk("R10 over cleared", r, 8'h00);
    @(negedge clk); fifo_unf = 1; wr_en = 1; addr = 8'h00; wr_data = 8'h10;
    @(negedge clk); fifo_unf = 0; wr_en = 0;
    rd(8'h00, r); chk("R10 event beats clear", r, 8'h10);
    wr(8'h00, 8'h10);
    rd(8'h00, r); chk("R10 under cleared", r, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule